// File: doc/BRIEF.md
# Rewindable FIFO Buffer with Half-Full Indication

This block is a single-clock first-in first-out buffer: 4096 words deep and 9 bits wide by default. Writes and reads are clocked enables. A read returns its word on a registered output, together with a one-cycle valid qualifier. Three active-low status flags show the fill state: empty, full, and more-than-half-full. The flags are registered and take their values from an internal occupancy count. Because that count can hold both 0 and the full depth, a full buffer is never mistaken for an empty one.

A rewind input sends the read side back to the first location written since the last reset. The write side is left alone, so the consumer can replay a packet after it finds an error. The synchronous reset and the rewind act only in a cycle in which neither enable is asserted. A request that arrives together with an enable is dropped, and a one-cycle error pulse marks it.

An empty buffer and a full buffer each have a pass-through behaviour. A word written into an empty buffer can be read in the next cycle. A read from a full buffer frees a slot that a waiting write can fill in the next cycle.

Top module: `fifo_rt`

## Requirements
- R1: A reset cycle with both enables low empties the buffer. Both positions return to location zero, so the next word written is the next word read. One cycle later `empty_n`=0, `full_n`=1 and `half_n`=1.
- R2: Words leave in the order they were accepted. An accepted read (`rd_en`=1 with `empty_n`=1) raises `rd_valid` for exactly one cycle, in the cycle after the read. `rd_data` holds the word in that same cycle.
- R3: After DEPTH accepted writes with no read, `full_n` is 0. A write while `full_n`=0 stores nothing and changes nothing: the next DEPTH reads return exactly the earlier words.
- R4: A read while `empty_n`=0 is ignored. `rd_valid` stays 0 and the buffer stays empty.
- R5: `empty_n` is 0 exactly when the occupancy is 0. `full_n` is 0 exactly when the occupancy is DEPTH. Both are registered and take their new value in the cycle after the operation.
- R6: `half_n` falls in the cycle after the write that takes the occupancy from DEPTH/2 to DEPTH/2+1. It rises in the cycle after the read that brings the occupancy back to DEPTH/2.
- R7: A rewind cycle (`rewind`=1, `rst`=0, both enables low) moves the read position to location zero and leaves the write position unchanged. The occupancy becomes the number of writes since the last reset, capped at DEPTH, and all flags follow it. Later reads replay from the first word written.
- R8: A read and a write in the same cycle, with neither flag active, are both accepted, and the occupancy stays the same.
- R9: A word written into an empty buffer can be read in the next cycle. It appears on `rd_data` one cycle after that read.
- R10: With the buffer full, a cycle that asserts both enables accepts only the read. A write in the next cycle is accepted, and the buffer is full again.
- R11: When `rst` or `rewind` is asserted in the same cycle as `wr_en` or `rd_en`, the reset or rewind is ignored. The enables act normally, and `err` is 1 in the next cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset request |
| wr_en | input | 1 | Write enable |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read enable |
| rewind | input | 1 | Return the read position to location zero |
| rd_data | output | 9 | Registered read word |
| rd_valid | output | 1 | High for one cycle when rd_data holds a fresh word |
| empty_n | output | 1 | Low when the buffer holds no word |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| half_n | output | 1 | Low when more than DEPTH/2 words are held |
| err | output | 1 | Pulse marking a dropped reset or rewind request |

## Verification
The checker examines a set of local cycle relations on every clock:
- A blocked write leaves the buffer full, and a blocked read leaves it empty.
- Every valid output follows an accepted read.
- The empty and full flags are never active together.
- The half flag only falls after a write or a rewind.
- The error pulse matches a conflicting request exactly.

The things that need a memory of the past come from the scoreboard's scenarios:
- the data order;
- the exact cycle at which the half flag crosses;
- the replay content after a rewind;
- the pass-through cycles at empty and full;
- the fact that a write refused while full leaves the stored words intact.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

    typedef struct packed {
        logic empty_n;
        logic full_n;
        logic half_n;
    } fifo_flags_t;

    typedef struct packed {
        logic clr;
        logic rwd;
        logic push;
        logic pop;
        logic clash;
    } fifo_ctl_t;

    function automatic fifo_ctl_t fifo_decode(
        input logic rst_req,
        input logic rwd_req,
        input logic wr_req,
        input logic rd_req,
        input fifo_flags_t fl
    );
        fifo_ctl_t c;
        logic busy;
        busy    = wr_req | rd_req;
        c.clash = (rst_req | rwd_req) & busy;
        c.clr   = rst_req & ~busy;
        c.rwd   = rwd_req & ~rst_req & ~busy;
        c.push  = wr_req & fl.full_n;
        c.pop   = rd_req & fl.empty_n;
        return c;
    endfunction

endpackage

// File: rtl/fifo_rt_ptrs.sv
module fifo_rt_ptrs
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic                       clk,
    input  fifo_ctl_t                  ctl,
    output logic [$clog2(DEPTH)-1:0]   wr_addr,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [$clog2(DEPTH+1)-1:0] fill_nxt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    logic [CW-1:0] fill_q;
    logic [CW-1:0] since_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
        return (a == LAST) ? '0 : a + 1'b1;
    endfunction

    always_comb begin
        fill_nxt = fill_q;
        if (ctl.clr) begin
            fill_nxt = '0;
        end else if (ctl.rwd) begin
            fill_nxt = since_q;
        end else if (ctl.push && !ctl.pop) begin
            fill_nxt = fill_q + 1'b1;
        end else if (ctl.pop && !ctl.push) begin
            fill_nxt = fill_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        fill_q <= fill_nxt;
        if (ctl.clr) begin
            wr_addr <= '0;
            rd_addr <= '0;
            since_q <= '0;
        end else if (ctl.rwd) begin
            rd_addr <= '0;
        end else begin
            if (ctl.push) begin
                wr_addr <= bump(wr_addr);
                if (since_q != FULLC) since_q <= since_q + 1'b1;
            end
            if (ctl.pop) rd_addr <= bump(rd_addr);
        end
    end
endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic                       clk,
    input  logic [$clog2(DEPTH+1)-1:0] fill_nxt,
    output fifo_flags_t                flags
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);
    localparam logic [CW-1:0] HALFC = CW'(DEPTH / 2);

    always_ff @(posedge clk) begin
        flags.empty_n <= (fill_nxt != '0);
        flags.full_n  <= (fill_nxt != FULLC);
        flags.half_n  <= (fill_nxt <= HALFC);
    end
endmodule

// File: rtl/fifo_rt_store.sv
module fifo_rt_store #(
    parameter int DEPTH = 4096,
    parameter int WIDTH = 9
) (
    input  logic                     clk,
    input  logic                     push,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     pop,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data,
    output logic                     rd_valid
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (push) mem[wr_addr] <= wr_data;
        if (pop)  rd_data <= mem[rd_addr];
        rd_valid <= pop;
    end
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rewind,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_n,
    output logic             err
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    fifo_flags_t   flags;
    fifo_ctl_t     ctl;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic [CW-1:0] fill_nxt;

    assign ctl = fifo_decode(rst, rewind, wr_en, rd_en, flags);

    fifo_rt_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .ctl(ctl), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .fill_nxt(fill_nxt)
    );

    fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .fill_nxt(fill_nxt), .flags(flags)
    );

    fifo_rt_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .push(ctl.push), .wr_addr(wr_addr), .wr_data(wr_data),
        .pop(ctl.pop), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_valid(rd_valid)
    );

    always_ff @(posedge clk) begin
        err <= ctl.clash;
    end

    assign empty_n = flags.empty_n;
    assign full_n  = flags.full_n;
    assign half_n  = flags.half_n;
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic rd_en,
    input logic rewind,
    input logic rd_valid,
    input logic empty_n,
    input logic full_n,
    input logic half_n,
    input logic err
);
    p_full_block_r3: assert property (@(posedge clk) disable iff (rst)
        (!full_n && wr_en && !rd_en) |=> !full_n);

    p_empty_block_r4: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && rd_en && !wr_en) |=> (!empty_n && !rd_valid));

    p_valid_src_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en && empty_n));

    p_flag_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(!empty_n && !full_n));

    p_half_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(half_n) |-> $past(wr_en || rewind));

    p_err_set_r11: assert property (@(posedge clk)
        ((rst || rewind) && (wr_en || rd_en)) |=> err);

    p_err_clr_r11: assert property (@(posedge clk)
        !((rst || rewind) && (wr_en || rd_en)) |=> !err);
endmodule

bind fifo_rt fifo_rt_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rewind(rewind),
    .rd_valid(rd_valid), .empty_n(empty_n), .full_n(full_n),
    .half_n(half_n), .err(err)
);

// File: tb/tb_fifo_rt.sv
module tb_fifo_rt;
    localparam int DEPTH = 4096;
    localparam int WIDTH = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic rewind = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic rd_valid, empty_n, full_n, half_n, err;

    int n_run = 0;
    int n_fail = 0;
    string cur = "R1";
    bit done = 0;

    logic [WIDTH-1:0] mmem [DEPTH];
    int mwr = 0, mrd = 0, mcnt = 0, mwrs = 0;
    logic [WIDTH-1:0] expq [$];
    bit exp_valid = 0, exp_err = 0;

    always #10 clk = ~clk;

    fifo_rt #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rewind(rewind), .rd_data(rd_data),
        .rd_valid(rd_valid), .empty_n(empty_n), .full_n(full_n),
        .half_n(half_n), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops the expected word whenever a word emerges
    always @(negedge clk) begin
        if (!done && rd_valid === 1'b1) begin
            if (expq.size() == 0) begin
                chk(0, {cur, " R2 unexpected word"}, int'(rd_data), -1);
            end else begin
                logic [WIDTH-1:0] e;
                e = expq.pop_front();
                chk(rd_data === e, {cur, " R2 data order"}, int'(rd_data), int'(e));
            end
        end
    end

    task automatic step(input bit w, input logic [WIDTH-1:0] d, input bit r,
                        input bit t, input bit s);
        bit busy, aw, ar;
        busy = w | r;
        exp_err = (s | t) & busy;
        aw = w && (mcnt != DEPTH);
        ar = r && (mcnt != 0);
        if (s && !busy) begin
            mwr = 0; mrd = 0; mcnt = 0; mwrs = 0;
        end else if (t && !s && !busy) begin
            mrd = 0; mcnt = mwrs;
        end else begin
            if (ar) begin
                expq.push_back(mmem[mrd]);
                mrd = (mrd + 1) % DEPTH;
            end
            if (aw) begin
                mmem[mwr] = d;
                mwr = (mwr + 1) % DEPTH;
                if (mwrs < DEPTH) mwrs++;
            end
            mcnt = mcnt + int'(aw) - int'(ar);
        end
        exp_valid = ar;
        wr_en = w; wr_data = d; rd_en = r; rewind = t; rst = s;
        @(posedge clk);
        @(negedge clk);
        #1;
        wr_en = 0; rd_en = 0; rewind = 0; rst = 0;
        chk(empty_n === (mcnt != 0), {cur, " R5 empty_n"}, int'(empty_n), int'(mcnt != 0));
        chk(full_n === (mcnt != DEPTH), {cur, " R5 full_n"}, int'(full_n), int'(mcnt != DEPTH));
        chk(half_n === (mcnt <= DEPTH/2), {cur, " R6 half_n"}, int'(half_n), int'(mcnt <= DEPTH/2));
        chk(rd_valid === exp_valid, {cur, " R2 rd_valid"}, int'(rd_valid), int'(exp_valid));
        chk(err === exp_err, {cur, " R11 err"}, int'(err), int'(exp_err));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset with idle enables
        cur = "R1";
        step(0, '0, 0, 0, 1);
        step(0, '0, 0, 0, 1);
        chk(expq.size() == 0, "R1 queue", expq.size(), 0);

        // R4: read while empty is ignored
        cur = "R4";
        step(0, '0, 1, 0, 0);
        step(0, '0, 1, 0, 0);

        // R9: write into empty, read next cycle
        cur = "R9";
        step(1, 9'h0A5, 0, 0, 0);
        step(0, '0, 1, 0, 0);
        idle(1);

        // R1: reset after traffic brings pointers back to zero
        cur = "R1";
        step(1, 9'h011, 0, 0, 0);
        step(1, 9'h022, 0, 0, 0);
        step(0, '0, 0, 0, 1);
        step(1, 9'h1C3, 0, 0, 0);
        step(0, '0, 1, 0, 0);
        idle(1);

        // R6 / R3: fill to half, cross it, then to full
        cur = "R6";
        for (int i = 0; i < DEPTH/2 + 1; i++) step(1, 9'((i * 37) ^ 9'h155), 0, 0, 0);
        step(0, '0, 1, 0, 0);                 // back to half: half_n rises
        step(1, 9'h0F0, 0, 0, 0);             // past half again: half_n falls
        cur = "R3";
        while (mcnt < DEPTH) step(1, 9'(mcnt * 11), 0, 0, 0);
        step(1, 9'h1FF, 0, 0, 0);             // write while full ignored
        step(1, 9'h1FE, 0, 0, 0);

        // R10: read and write together on full, then write next cycle
        cur = "R10";
        step(1, 9'h1AA, 1, 0, 0);
        step(1, 9'h1AB, 0, 0, 0);
        chk(full_n === 1'b0, "R10 full again", int'(full_n), 0);

        // R8: simultaneous read and write mid-fill
        cur = "R8";
        for (int i = 0; i < 8; i++) step(0, '0, 1, 0, 0);
        for (int i = 0; i < 16; i++) step(1, 9'(i + 200), 1, 0, 0);

        // R3: drain everything; the refused words must never appear
        cur = "R3";
        while (mcnt > 0) step(0, '0, 1, 0, 0);
        idle(1);
        chk(expq.size() == 0, "R3 all drained", expq.size(), 0);

        // R7: rewind replays from the first word after reset
        cur = "R7";
        step(0, '0, 0, 0, 1);
        for (int i = 0; i < 5; i++) step(1, 9'(i + 40), 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, '0, 1, 0, 0);
        step(0, '0, 0, 1, 0);
        chk(mcnt == 5, "R7 model fill", mcnt, 5);
        for (int i = 0; i < 5; i++) step(0, '0, 1, 0, 0);
        idle(1);

        // R7: rewind after a full load restores a full buffer
        step(0, '0, 0, 0, 1);
        while (mcnt < DEPTH) step(1, 9'(mcnt + 3), 0, 0, 0);
        for (int i = 0; i < DEPTH/2 + 4; i++) step(0, '0, 1, 0, 0);
        step(0, '0, 0, 1, 0);
        step(0, '0, 1, 0, 0);
        idle(1);

        // R11: conflicting reset and rewind are dropped
        cur = "R11";
        step(0, '0, 0, 0, 1);
        step(1, 9'h033, 0, 0, 1);             // reset dropped, write kept
        step(1, 9'h044, 0, 0, 0);
        step(0, '0, 1, 1, 0);                 // rewind dropped, read kept
        step(0, '0, 0, 0, 0);
        chk(mcnt == 1, "R11 fill kept", mcnt, 1);
        step(0, '0, 1, 0, 0);
        idle(2);
        chk(expq.size() == 0, "R11 queue drained", expq.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule